// File: doc/BRIEF.md
# Busy-Gated Trigger Acceptance Unit

This unit sits at the end of a trigger chain. Five trigger lines come in: a coincidence trigger, a primary singles trigger, a secondary singles trigger and two external inputs. Each line is one bit of `src_in`, so the bit order is fixed: bit 0 is coincidence, bit 1 is primary singles, bit 2 is secondary singles, bit 3 is external A and bit 4 is external B. A host-written enable mask chooses which of these lines are ORed into the raw trigger.

A raw trigger passes through as a live trigger only while the busy latch is clear. A live trigger sets the busy latch after a fixed delay of `BUSY_DELAY` cycles; the default of 2 cycles is 50 ns at 40 MHz. In the same edge it raises a latched event request to the host. The first live trigger of an event copies the state of all source lines into a pattern register. The host reads that pattern word first, before any other event data, and then writes a clear command that drops both latches.

One physical event can make the raw trigger pulse more than once. For that reason, every input line and the raw trigger each have their own saturating edge counter. All registers are reached through plain read and write strobes.

Top module: `trig_accept_unit`

## Requirements
- R1: While busy is low, `live_trig` is high in exactly the cycles in which `src_in & mask` is nonzero. Mask bit i enables `src_in` bit i.
- R2: While busy is high, `live_trig` stays low whatever the sources and mask do.
- R3: A live trigger in cycle t leaves busy and `evt_req` low in cycle t+1. Both read high from cycle t+BUSY_DELAY onward (t+2 by default).
- R4: A second live trigger inside the delay window still shows on `live_trig`, but the pattern register keeps the value captured by the first one.
- R5: The pattern register at address 0x0 holds all five `src_in` bits, unmasked, as sampled in the accepting cycle. Reading it has no side effects.
- R6: Writing address 0x3 with bit 0 set clears busy and `evt_req` at the next edge. Apart from that write, both latches hold their value.
- R7: Each source has an edge counter at address 0x5+i, which counts rising edges of `src_in` bit i whether or not the mask enables it.
- R8: The raw-trigger counter at address 0x4 counts rising edges of the masked OR.
- R9: Every counter stops at its all-ones value and does not wrap.
- R10: Writing address 0x3 with bit 1 set clears all counters to zero.
- R11: A read strobe returns data with `host_rd_valid` one cycle later. The mask at 0x1 reads back as written, the status at 0x2 is {evt_req, busy} in bits 1:0, and unmapped addresses and 0x3 read zero.
- R12: After reset, busy, `evt_req`, the mask, the pattern and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 5 | Trigger source lines, in the bit order given above |
| live_trig | output | 1 | Accepted trigger (combinational from the sources) |
| busy | output | 1 | Busy latch |
| evt_req | output | 1 | Latched event request to the host |
| host_wr_en | input | 1 | Register write strobe |
| host_rd_en | input | 1 | Register read strobe |
| host_addr | input | ADDR_W | Register address, shared by reads and writes |
| host_wdata | input | DATA_W | Write data |
| host_rd_data | output | DATA_W | Read data, registered |
| host_rd_valid | output | 1 | Read data valid, one cycle after `host_rd_en` |

## Verification
The bench builds the unit with `CNT_W=4` and keeps the default delay of two cycles. With 4-bit counters, saturation is reached after fifteen edges, so it is exercised many times within the sweep. The sweep covers all 32 masks against all 32 source patterns. For each combination the bench checks the acceptance decision, the exact busy timing, the captured pattern and every counter, all predicted arithmetically. A separate sequence fires triggers back to back inside the delay window and keeps firing while busy is set.

// File: rtl/tgu_pkg.sv
package tgu_pkg;
  localparam int SRC_N = 5;
  // source line positions inside the pattern word
  localparam int SRC_COINC = 0;
  localparam int SRC_PRIM  = 1;
  localparam int SRC_SEC   = 2;
  localparam int SRC_EXTA  = 3;
  localparam int SRC_EXTB  = 4;
  // register map
  localparam int ADR_PATTERN = 'h0;
  localparam int ADR_MASK    = 'h1;
  localparam int ADR_STATUS  = 'h2;
  localparam int ADR_CMD     = 'h3;
  localparam int ADR_RAWCNT  = 'h4;
  localparam int ADR_SRCCNT0 = 'h5;
  // command bits
  localparam int CMD_CLR_BUSY = 0;
  localparam int CMD_CLR_CNT  = 1;
endpackage

// File: rtl/tgu_edge_counter.sv
module tgu_edge_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             level_in,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic prev_q;
  logic rise;

  assign rise = level_in & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      count  <= '0;
    end else begin
      prev_q <= level_in;
      if (clr)
        count <= '0;
      else if (rise && count != CNT_MAX)
        count <= count + 1'b1;
    end
  end

  // R9: a full counter stays full
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !clr) |=> count == CNT_MAX);
  // R7: count never decreases without a clear
  a_r7_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> count >= $past(count));
  // R10: clear empties the counter
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
endmodule

// File: rtl/tgu_busy_ctl.sv
module tgu_busy_ctl #(
  parameter int SRC_W      = 5,
  parameter int BUSY_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raw,
  input  logic [SRC_W-1:0] src,
  input  logic             clr_busy,
  output logic             live,
  output logic             busy,
  output logic             evt_req,
  output logic [SRC_W-1:0] pattern
);
  // BUSY_DELAY must be at least 2: the pipe has one stage fewer than the delay
  localparam int PIPE_W = BUSY_DELAY - 1;

  logic [PIPE_W-1:0] pipe_q;
  logic              window;

  assign live   = raw & ~busy;
  assign window = |pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else if (clr_busy) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= live;
      for (int i = 1; i < PIPE_W; i++)
        pipe_q[i] <= pipe_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      evt_req <= 1'b0;
    end else if (clr_busy) begin
      busy    <= 1'b0;
      evt_req <= 1'b0;
    end else if (pipe_q[PIPE_W-1]) begin
      busy    <= 1'b1;
      evt_req <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pattern <= '0;
    else if (live && !window)
      pattern <= src;
  end

  // R6: latches hold until the host clears them
  a_r6_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr_busy) |=> busy);
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |=> (!busy && !evt_req));
  // R3: request rises only together with busy
  a_r3_req_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_req) |-> $rose(busy));
  // R5: first acceptance captures the source lines
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !window) |=> pattern == $past(src));
  // R4: later acceptances in the window leave the pattern alone
  a_r4_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (live && window) |=> $stable(pattern));
endmodule

// File: rtl/trig_accept_unit.sv
module trig_accept_unit
  import tgu_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 4,
  parameter int BUSY_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_N-1:0]  src_in,
  output logic              live_trig,
  output logic              busy,
  output logic              evt_req,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rd_data,
  output logic              host_rd_valid
);
  logic [SRC_N-1:0]  mask_q;
  logic [SRC_N-1:0]  pattern;
  logic              raw;
  logic              wr_cmd;
  logic              clr_busy;
  logic              clr_cnt;
  logic [CNT_W-1:0]  raw_cnt;
  logic [CNT_W-1:0]  src_cnt [SRC_N];
  logic [DATA_W-1:0] rd_mux;
  logic              wdata_unused;

  assign wdata_unused = ^host_wdata[DATA_W-1:SRC_N];

  assign raw      = |(src_in & mask_q);
  assign wr_cmd   = host_wr_en && (host_addr == ADDR_W'(ADR_CMD));
  assign clr_busy = wr_cmd & host_wdata[CMD_CLR_BUSY];
  assign clr_cnt  = wr_cmd & host_wdata[CMD_CLR_CNT];

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '0;
    else if (host_wr_en && host_addr == ADDR_W'(ADR_MASK))
      mask_q <= host_wdata[SRC_N-1:0];
  end

  tgu_busy_ctl #(
    .SRC_W      (SRC_N),
    .BUSY_DELAY (BUSY_DELAY)
  ) u_busy (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw      (raw),
    .src      (src_in),
    .clr_busy (clr_busy),
    .live     (live_trig),
    .busy     (busy),
    .evt_req  (evt_req),
    .pattern  (pattern)
  );

  tgu_edge_counter #(.CNT_W(CNT_W)) u_raw_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_cnt),
    .level_in (raw),
    .count    (raw_cnt)
  );

  for (genvar g = 0; g < SRC_N; g++) begin : g_src_cnt
    tgu_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_cnt),
      .level_in (src_in[g]),
      .count    (src_cnt[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (host_addr == ADDR_W'(ADR_PATTERN))
      rd_mux = DATA_W'(pattern);
    else if (host_addr == ADDR_W'(ADR_MASK))
      rd_mux = DATA_W'(mask_q);
    else if (host_addr == ADDR_W'(ADR_STATUS))
      rd_mux = DATA_W'({evt_req, busy});
    else if (host_addr == ADDR_W'(ADR_RAWCNT))
      rd_mux = DATA_W'(raw_cnt);
    for (int i = 0; i < SRC_N; i++)
      if (host_addr == ADDR_W'(ADR_SRCCNT0 + i))
        rd_mux = DATA_W'(src_cnt[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rd_data  <= '0;
      host_rd_valid <= 1'b0;
    end else begin
      host_rd_valid <= host_rd_en;
      if (host_rd_en)
        host_rd_data <= rd_mux;
    end
  end

  // R11: a read strobe is answered in the next cycle
  a_r11_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd_en |=> host_rd_valid);
  // R2: no acceptance in a cycle where busy stayed set
  a_r2_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !live_trig);
endmodule

// File: tb/trig_accept_unit_bench.sv
module trig_accept_unit_bench;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_in = '0;
  logic        live_trig, busy, evt_req;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rd_data;
  logic        host_rd_valid;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  trig_accept_unit #(.CNT_W(CW)) u_trig_accept_unit (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .live_trig(live_trig),
    .busy(busy), .evt_req(evt_req), .host_wr_en(host_wr_en),
    .host_rd_en(host_rd_en), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd_data(host_rd_data), .host_rd_valid(host_rd_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd_en = 1'b0;
    chk(host_rd_valid == 1'b1, "R11 valid", 32'(host_rd_valid), 1);
    d = host_rd_data;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int exp_src [5];
    int exp_raw;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    @(negedge clk);
    chk(busy == 0 && evt_req == 0, "R12 latches", {busy, evt_req}, 0);
    rd_chk(4'h0, 0, "R12 pattern");
    rd_chk(4'h1, 0, "R12 mask");
    rd_chk(4'h4, 0, "R12 rawcnt");
    for (int i = 0; i < 5; i++) rd_chk(4'(5 + i), 0, "R12 srccnt");

    // R11 unmapped and command reads
    rd_chk(4'hF, 0, "R11 unmapped");
    rd_chk(4'h3, 0, "R11 cmd reads zero");

    // sweep every mask against every pattern
    for (int m = 0; m < 32; m++) begin
      wr(4'h1, 32'(m));
      wr(4'h3, 32'h3);
      rd_chk(4'h4, 0, "R10 cleared rawcnt");
      rd_chk(4'h1, 32'(m), "R11 mask readback");
      exp_raw = 0;
      for (int i = 0; i < 5; i++) exp_src[i] = 0;
      for (int p = 0; p < 32; p++) begin
        bit acc;
        acc = ((p & m) != 0);
        @(negedge clk);
        src_in = 5'(p);
        #1 chk(live_trig == acc, "R1 live", 32'(live_trig), 32'(acc));
        @(negedge clk);
        src_in = '0;
        #1 chk(busy == 0, "R3 not early", 32'(busy), 0);
        @(negedge clk);
        #1 chk(busy == acc && evt_req == acc, "R3 busy/req", {busy, evt_req}, {acc, acc});
        for (int i = 0; i < 5; i++)
          if (p[i] && exp_src[i] < CMAX) exp_src[i]++;
        if (acc && exp_raw < CMAX) exp_raw++;
        if (acc) begin
          rd_chk(4'h0, 32'(p), "R5 pattern");
          rd_chk(4'h0, 32'(p), "R5 reread");
          rd_chk(4'h2, 32'h3, "R11 status");
          wr(4'h3, 32'h1);
          chk(busy == 0 && evt_req == 0, "R6 clear", {busy, evt_req}, 0);
        end
        rd_chk(4'h4, 32'(exp_raw), exp_raw == CMAX ? "R9 raw sat" : "R8 rawcnt");
        for (int i = 0; i < 5; i++)
          rd_chk(4'(5 + i), 32'(exp_src[i]), exp_src[i] == CMAX ? "R9 src sat" : "R7 srccnt");
      end
    end

    // R4 window: back-to-back acceptances, pattern keeps the first
    wr(4'h1, 32'h1F);
    wr(4'h3, 32'h3);
    @(negedge clk);
    src_in = 5'b00011;
    #1 chk(live_trig == 1, "R4 first live", 32'(live_trig), 1);
    @(negedge clk);
    src_in = 5'b10100;
    #1 chk(live_trig == 1, "R4 window live", 32'(live_trig), 1);
    @(negedge clk);
    src_in = 5'b01000;
    #1 chk(live_trig == 0 && busy == 1, "R2 blocked", {live_trig, busy}, 1);
    @(negedge clk);
    src_in = '0;
    rd_chk(4'h0, 32'h03, "R4 pattern kept");

    // R2/R6 busy holds through more triggers
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      src_in = (k % 2 == 0) ? 5'h1F : 5'h00;
      #1 chk(live_trig == 0 && busy == 1, "R2 held off", {live_trig, busy}, 1);
    end
    @(negedge clk);
    src_in = '0;
    rd_chk(4'h0, 32'h03, "R6 pattern held");
    chk(evt_req == 1, "R6 req held", 32'(evt_req), 1);
    wr(4'h3, 32'h1);
    chk(busy == 0 && evt_req == 0, "R6 clear", {busy, evt_req}, 0);
    @(negedge clk);
    src_in = 5'b00010;
    #1 chk(live_trig == 1, "R1 accept after clear", 32'(live_trig), 1);
    @(negedge clk);
    src_in = '0;
    @(negedge clk);
    rd_chk(4'h0, 32'h02, "R5 new pattern");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule